// File: doc/BRIEF.md
# Parallel Addressable-LED Frame Serializer

This block plays a stored frame of pixel colours out to a row of single-wire addressable LED strands, all driven at the same time by one shared timing engine. A writer elsewhere fills one of two frame banks in an external read-only memory port and then pulses a commit with that bank's number. The serializer starts a frame from the committed bank as soon as it is free. For each pixel index it reads the word of every active strand. It then sends 24 bits per strand on all lines in lockstep at one bit every `T_BIT` clocks, which is 800 kbit/s at the intended clock. The frame ends with a quiet low period that makes the LEDs latch the new colours.

Strand count and strand length are runtime inputs, taken once when a frame starts. The frame memory is laid out strand-major inside each bank. While one pixel is on the wire, the words for the next pixel index are fetched into holding registers, so the memory port is used for only a few dozen cycles out of every pixel time. A commit that arrives while a frame is playing is remembered and served after the quiet period. The writer is expected to fill only the bank that is not reported on `shown_bank` while `busy` is high.

Top module: `ws_frame_serializer`

## Requirements
- R1: After reset, `busy` is 0, `shown_bank` is 0, `mem_rd_en` is 0 and every `led_out` line is low.
- R2: A `commit` pulse sampled while the block is idle is stored, and `busy` rises one clock later. The frame is read from bank `commit_bank`, and `shown_bank` shows that bank from the rise of `busy` until the next frame starts.
- R3: Each bit occupies `T_BIT` clocks on a line. A 0 bit is high for the first `T0H` clocks and a 1 bit is high for the first `T1H` clocks. The line is low for the rest of the bit time.
- R4: The memory word has red in bits 23:16, green in bits 15:8 and blue in bits 7:0, and bits 31:24 are ignored. The line sends green first, then red, then blue, each byte most significant bit first.
- R5: Lane `o`, pixel `p` comes from address `bank*NUM_LANES*MAX_PIX + o*P + p`, where `P` is the effective strand length. Pixels go out in ascending `p` on all lanes at once.
- R6: Lanes with an index at or above the effective lane count stay low for the whole frame. A lane count above `NUM_LANES` counts as `NUM_LANES`. Lane count and strand length are sampled only when a frame starts, and changes during a frame have no effect on it.
- R7: A strand length of 0 counts as 1 and a length above `MAX_PIX` counts as `MAX_PIX`. `busy` stays high for exactly `NUM_LANES+2 + P*24*T_BIT + RESET_CYC` clocks.
- R8: After the last bit, all lines stay low for `RESET_CYC` clocks while `busy` is still high. While `busy` is low, every line is low.
- R9: A commit that arrives during a frame starts the next frame after a single idle clock that follows the quiet period. When several commits arrive, the bank of the last one is used.
- R10: The first bit of a frame starts on `led_out` exactly `NUM_LANES+3` clocks after `busy` rises, and all lines are low before that. No memory read is issued while `busy` is low.
- R11: Every memory read during a frame addresses the bank shown on `shown_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | One-clock pulse: a finished frame is ready |
| commit_bank | input | 1 | Bank that holds the finished frame |
| cfg_lanes | input | LANE_W | Requested number of active lanes |
| cfg_pixels | input | PIX_W | Requested pixels per lane |
| mem_rd_en | output | 1 | Frame memory read strobe |
| mem_rd_addr | output | ADDR_W | Frame memory word address |
| mem_rd_data | input | 32 | Read data, valid the clock after the strobe |
| busy | output | 1 | A frame (prefetch, bits or quiet period) is in progress |
| shown_bank | output | 1 | Bank of the current or last frame |
| led_out | output | NUM_LANES | Serial data lines, one per strand |

## Verification
The reference model replays every frame clock by clock from its own copy of the memory. The bench targets a green/red byte swap, which would put the wrong byte on the wire in the first 8 bit times, and an all-ones word next to an all-zeros word, which would show up any mix-up between the two high times. It also targets a lane count that changes mid-frame and a strand length pushed to 0 and past the maximum: a design that resampled or failed to clamp these would stretch or cut the frame and turn on extra lanes. Two commits during a frame check that the last bank wins after exactly one idle clock. A broken prefetch would show as stale pixels from the second pixel onward, or as reads outside the shown bank.

// File: rtl/ws_ser_pkg.sv
package ws_ser_pkg;

    localparam int unsigned BITS_PER_PIXEL = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEND,
        ST_GAP
    } ser_state_t;

    typedef logic [BITS_PER_PIXEL-1:0] wire_word_t;

    // bit-clock status shared by the sequencer and the lane shifters
    typedef struct packed {
        logic run;
        logic bit_last;
        logic word_last;
        logic zero_hi;
        logic one_hi;
    } bit_tick_t;

    // memory word 0x00RRGGBB -> order on the line: G, R, B
    function automatic wire_word_t to_wire_order(input logic [31:0] w);
        return {w[15:8], w[23:16], w[7:0]};
    endfunction

endpackage

// File: rtl/ws_bit_clock.sv
module ws_bit_clock
    import ws_ser_pkg::*;
#(
    parameter int unsigned T_BIT = 62,
    parameter int unsigned T0H   = 20,
    parameter int unsigned T1H   = 40
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output bit_tick_t tick
);
    localparam int unsigned PH_W = $clog2(T_BIT);
    localparam int unsigned BN_W = $clog2(BITS_PER_PIXEL);

    logic [PH_W-1:0] phase_q;
    logic [BN_W-1:0] bitn_q;
    logic            at_bit_end;
    logic            at_word_end;

    assign at_bit_end  = (phase_q == PH_W'(T_BIT - 1));
    assign at_word_end = at_bit_end && (bitn_q == BN_W'(BITS_PER_PIXEL - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
            bitn_q  <= '0;
        end else if (at_bit_end) begin
            phase_q <= '0;
            bitn_q  <= at_word_end ? '0 : bitn_q + BN_W'(1);
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    always_comb begin
        tick.run       = run;
        tick.bit_last  = run && at_bit_end;
        tick.word_last = run && at_word_end;
        tick.zero_hi   = (phase_q < PH_W'(T0H));
        tick.one_hi    = (phase_q < PH_W'(T1H));
    end

endmodule

// File: rtl/ws_fetch_unit.sv
module ws_fetch_unit
    import ws_ser_pkg::*;
#(
    parameter int unsigned NUM_LANES = 30,
    parameter int unsigned LANE_W    = 5,
    parameter int unsigned PIX_W     = 11,
    parameter int unsigned ADDR_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        base,
    input  logic [PIX_W-1:0]         stride,
    input  logic [LANE_W-1:0]        lanes,
    output logic                     rd_en,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic [31:0]              rd_data,
    output wire_word_t [NUM_LANES-1:0] words
);
    logic              issuing_q;
    logic [LANE_W-1:0] idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              cap_valid_q;
    logic [LANE_W-1:0] cap_idx_q;
    logic [7:0]        unused_pad;

    assign unused_pad = rd_data[31:24];
    assign rd_en      = issuing_q;
    assign rd_addr    = addr_q;

    // one read per clock, lane by lane, stepping one strand length apart
    always_ff @(posedge clk) begin
        if (rst) begin
            issuing_q <= 1'b0;
            idx_q     <= '0;
            addr_q    <= '0;
        end else if (start) begin
            issuing_q <= (lanes != '0);
            idx_q     <= '0;
            addr_q    <= base;
        end else if (issuing_q) begin
            if (idx_q + LANE_W'(1) == lanes) begin
                issuing_q <= 1'b0;
            end
            idx_q  <= idx_q + LANE_W'(1);
            addr_q <= addr_q + ADDR_W'(stride);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid_q <= 1'b0;
            cap_idx_q   <= '0;
        end else begin
            cap_valid_q <= issuing_q;
            cap_idx_q   <= idx_q;
        end
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_hold
        wire_word_t hold_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
            end else if (cap_valid_q && cap_idx_q == LANE_W'(i)) begin
                hold_q <= to_wire_order(rd_data);
            end
        end
        assign words[i] = hold_q;
    end

endmodule

// File: rtl/ws_lane_shifters.sv
module ws_lane_shifters
    import ws_ser_pkg::*;
#(
    parameter int unsigned NUM_LANES = 30,
    parameter int unsigned LANE_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic                       shift,
    input  wire_word_t [NUM_LANES-1:0] words,
    input  logic [LANE_W-1:0]          lane_count,
    input  bit_tick_t                  tick,
    output logic [NUM_LANES-1:0]       lines
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        wire_word_t sr_q;
        logic       line_q;
        logic       lane_on;

        assign lane_on = (LANE_W'(i) < lane_count);

        always_ff @(posedge clk) begin
            if (rst) begin
                sr_q <= '0;
            end else if (load) begin
                sr_q <= words[i];
            end else if (shift) begin
                sr_q <= {sr_q[BITS_PER_PIXEL-2:0], 1'b0};
            end
        end

        // registered pin: high window picked by the current MSB
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= 1'b0;
            end else begin
                line_q <= tick.run && lane_on &&
                          (sr_q[BITS_PER_PIXEL-1] ? tick.one_hi : tick.zero_hi);
            end
        end

        assign lines[i] = line_q;
    end

endmodule

// File: rtl/ws_frame_serializer.sv
module ws_frame_serializer
    import ws_ser_pkg::*;
#(
    parameter int unsigned NUM_LANES = 30,
    parameter int unsigned MAX_PIX   = 1024,
    parameter int unsigned T_BIT     = 62,
    parameter int unsigned T0H       = 20,
    parameter int unsigned T1H       = 40,
    parameter int unsigned RESET_CYC = 2600,
    localparam int unsigned LANE_W     = $clog2(NUM_LANES + 1),
    localparam int unsigned PIX_W      = $clog2(MAX_PIX + 1),
    localparam int unsigned BANK_WORDS = NUM_LANES * MAX_PIX,
    localparam int unsigned ADDR_W     = $clog2(2 * BANK_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  logic                 commit_bank,
    input  logic [LANE_W-1:0]    cfg_lanes,
    input  logic [PIX_W-1:0]     cfg_pixels,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic [31:0]          mem_rd_data,
    output logic                 busy,
    output logic                 shown_bank,
    output logic [NUM_LANES-1:0] led_out
);
    localparam int unsigned LOAD_CYC = NUM_LANES + 2;
    localparam int unsigned LC_W     = $clog2(LOAD_CYC);
    localparam int unsigned GAP_W    = $clog2(RESET_CYC);
    localparam int unsigned PX1_W    = PIX_W + 1;

    ser_state_t         state_q;
    logic [LC_W-1:0]    lcnt_q;
    logic [GAP_W-1:0]   gcnt_q;
    logic [PIX_W-1:0]   pix_idx_q;
    logic [LANE_W-1:0]  lanes_q;
    logic [PIX_W-1:0]   pix_q;
    logic               bank_q;
    logic               pend_q;
    logic               pend_bank_q;

    logic [LANE_W-1:0]  lanes_in;
    logic [PIX_W-1:0]   pix_in;
    bit_tick_t          tick;
    logic               last_pix;
    logic               start_frame;
    logic               load_first;
    logic               load_next;
    logic               shift_bit;
    logic               more_after_next;
    logic               fetch_start;
    logic [PX1_W-1:0]   fetch_pix;
    logic               fetch_bank;
    logic [ADDR_W-1:0]  fetch_base;
    logic [PIX_W-1:0]   fetch_stride;
    logic [LANE_W-1:0]  fetch_lanes;
    wire_word_t [NUM_LANES-1:0] next_words;

    // ---- runtime configuration, clamped ----
    always_comb begin
        lanes_in = (cfg_lanes > LANE_W'(NUM_LANES)) ? LANE_W'(NUM_LANES) : cfg_lanes;
        if (cfg_pixels == '0) begin
            pix_in = PIX_W'(1);
        end else if (cfg_pixels > PIX_W'(MAX_PIX)) begin
            pix_in = PIX_W'(MAX_PIX);
        end else begin
            pix_in = cfg_pixels;
        end
    end

    // ---- frame sequencing ----
    assign last_pix        = (pix_idx_q == pix_q - PIX_W'(1));
    assign start_frame     = (state_q == ST_IDLE) && pend_q;
    assign load_first      = (state_q == ST_LOAD) && (lcnt_q == LC_W'(LOAD_CYC - 1));
    assign load_next       = (state_q == ST_SEND) && tick.word_last && !last_pix;
    assign shift_bit       = (state_q == ST_SEND) && tick.bit_last && !tick.word_last;
    assign more_after_next = ({1'b0, pix_idx_q} + PX1_W'(2)) < {1'b0, pix_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            lcnt_q    <= '0;
            gcnt_q    <= '0;
            pix_idx_q <= '0;
            lanes_q   <= '0;
            pix_q     <= PIX_W'(1);
            bank_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pend_q) begin
                        state_q <= ST_LOAD;
                        lcnt_q  <= '0;
                        lanes_q <= lanes_in;
                        pix_q   <= pix_in;
                        bank_q  <= pend_bank_q;
                    end
                end
                ST_LOAD: begin
                    if (load_first) begin
                        state_q   <= ST_SEND;
                        pix_idx_q <= '0;
                    end else begin
                        lcnt_q <= lcnt_q + LC_W'(1);
                    end
                end
                ST_SEND: begin
                    if (tick.word_last) begin
                        if (last_pix) begin
                            state_q <= ST_GAP;
                            gcnt_q  <= '0;
                        end else begin
                            pix_idx_q <= pix_idx_q + PIX_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt_q == GAP_W'(RESET_CYC - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        gcnt_q <= gcnt_q + GAP_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // ---- commit capture: newest commit wins ----
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_bank_q <= 1'b0;
        end else if (commit) begin
            pend_q      <= 1'b1;
            pend_bank_q <= commit_bank;
        end else if (start_frame) begin
            pend_q <= 1'b0;
        end
    end

    // ---- prefetch control ----
    always_comb begin
        fetch_start = start_frame
                    | (load_first && pix_q > PIX_W'(1))
                    | (load_next && more_after_next);
        if (start_frame) begin
            fetch_pix = '0;
        end else if (load_first) begin
            fetch_pix = PX1_W'(1);
        end else begin
            fetch_pix = {1'b0, pix_idx_q} + PX1_W'(2);
        end
        fetch_bank   = start_frame ? pend_bank_q : bank_q;
        fetch_stride = start_frame ? pix_in : pix_q;
        fetch_lanes  = start_frame ? lanes_in : lanes_q;
        fetch_base   = (fetch_bank ? ADDR_W'(BANK_WORDS) : ADDR_W'(0)) + ADDR_W'(fetch_pix);
    end

    ws_fetch_unit #(
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W),
        .PIX_W     (PIX_W),
        .ADDR_W    (ADDR_W)
    ) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .start   (fetch_start),
        .base    (fetch_base),
        .stride  (fetch_stride),
        .lanes   (fetch_lanes),
        .rd_en   (mem_rd_en),
        .rd_addr (mem_rd_addr),
        .rd_data (mem_rd_data),
        .words   (next_words)
    );

    ws_bit_clock #(
        .T_BIT (T_BIT),
        .T0H   (T0H),
        .T1H   (T1H)
    ) u_clock (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_SEND),
        .tick (tick)
    );

    ws_lane_shifters #(
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W)
    ) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .load       (load_first | load_next),
        .shift      (shift_bit),
        .words      (next_words),
        .lane_count (lanes_q),
        .tick       (tick),
        .lines      (led_out)
    );

    assign busy       = (state_q != ST_IDLE);
    assign shown_bank = bank_q;

endmodule

// File: rtl/ws_ser_checks.sv
module ws_ser_checks #(
    parameter int unsigned NUM_LANES  = 30,
    parameter int unsigned LANE_W     = 5,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned BANK_WORDS = 30720
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 shown_bank,
    input logic                 mem_rd_en,
    input logic [ADDR_W-1:0]    mem_rd_addr,
    input logic [NUM_LANES-1:0] led_out,
    input logic [LANE_W-1:0]    lanes_q,
    input logic                 pend_q
);
    logic [NUM_LANES-1:0] lane_mask;
    int unsigned          bank_lo;

    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_mask[i] = (i < int'(lanes_q));
        end
        bank_lo = shown_bank ? BANK_WORDS : 0;
    end

    assert_idle_lines_low_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (led_out == '0));

    assert_inactive_lanes_low_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((led_out & ~lane_mask) == '0));

    assert_read_in_shown_bank_R11: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (int'(mem_rd_addr) >= bank_lo && int'(mem_rd_addr) < bank_lo + BANK_WORDS));

    assert_no_read_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en);

    assert_start_follows_commit_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(pend_q));

    assert_bank_held_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(shown_bank));

endmodule

bind ws_frame_serializer ws_ser_checks #(
    .NUM_LANES  (NUM_LANES),
    .LANE_W     (LANE_W),
    .ADDR_W     (ADDR_W),
    .BANK_WORDS (BANK_WORDS)
) u_checks (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .shown_bank  (shown_bank),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .led_out     (led_out),
    .lanes_q     (lanes_q),
    .pend_q      (pend_q)
);

// File: tb/ws_frame_serializer_test.sv
module ws_frame_serializer_test;

    localparam int NL    = 30;
    localparam int MP    = 16;
    localparam int TB    = 10;
    localparam int T0    = 3;
    localparam int T1    = 7;
    localparam int RC    = 40;
    localparam int LW    = $clog2(NL + 1);
    localparam int PW    = $clog2(MP + 1);
    localparam int BW    = NL * MP;
    localparam int AW    = $clog2(2 * BW);
    localparam int LOADC = NL + 2;
    localparam int LEAD  = NL + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          commit = 1'b0;
    logic          commit_bank = 1'b0;
    logic [LW-1:0] cfg_lanes = '0;
    logic [PW-1:0] cfg_pixels = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data;
    logic          busy;
    logic          shown_bank;
    logic [NL-1:0] led_out;

    always #10 clk = ~clk;

    ws_frame_serializer #(
        .NUM_LANES (NL),
        .MAX_PIX   (MP),
        .T_BIT     (TB),
        .T0H       (T0),
        .T1H       (T1),
        .RESET_CYC (RC)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_bank (commit_bank),
        .cfg_lanes   (cfg_lanes),
        .cfg_pixels  (cfg_pixels),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .busy        (busy),
        .shown_bank  (shown_bank),
        .led_out     (led_out)
    );

    // frame memory with one clock of read latency
    logic [31:0] mem [2*BW];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    int m_act, m_t, m_total, m_L, m_P, m_bank, m_pend, m_pbank, m_mid, m_pend_mid;
    logic [31:0] fw [NL][MP];

    function automatic int clamp_lanes(int v); return (v > NL) ? NL : v; endfunction
    function automatic int clamp_pix(int v);
        if (v == 0) return 1;
        return (v > MP) ? MP : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_t = 0; m_total = 0; m_L = 0; m_P = 1;
            m_bank = 0; m_pend = 0; m_pbank = 0; m_mid = 0; m_pend_mid = 0;
        end else begin
            if (m_act != 0) begin
                m_t++;
                if (m_t == m_total) m_act = 0;
            end else if (m_pend != 0) begin
                m_L = clamp_lanes(int'(cfg_lanes));
                m_P = clamp_pix(int'(cfg_pixels));
                m_bank = m_pbank;
                for (int o = 0; o < NL; o++)
                    for (int p = 0; p < MP; p++)
                        fw[o][p] = (p < m_P) ? mem[m_bank*BW + o*m_P + p] : 32'h0;
                m_total = LOADC + m_P*24*TB + RC;
                m_t = 0; m_act = 1; m_pend = 0; m_mid = m_pend_mid;
            end
            if (commit) begin
                m_pend = 1; m_pbank = int'(commit_bank); m_pend_mid = m_act;
            end
        end
    end

    function automatic bit exp_line(int o);
        int k, pix, bt, ph;
        logic [31:0] w;
        logic [23:0] g;
        if (m_act == 0) return 1'b0;
        k = m_t - LEAD;
        if (k < 0 || k >= m_P*24*TB || o >= m_L) return 1'b0;
        pix = k / (24*TB);
        bt  = (k / TB) % 24;
        ph  = k % TB;
        w   = fw[o][pix];
        g   = {w[15:8], w[23:16], w[7:0]};
        return (ph < (g[23-bt] ? T1 : T0));
    endfunction

    function automatic string line_tag(int o);
        int k, ph;
        if (m_act == 0) return "R8";
        k = m_t - LEAD;
        if (k < 0) return "R10";
        if (k >= m_P*24*TB) return "R8";
        if (o >= m_L) return "R6";
        ph = k % TB;
        if (ph < T0 || ph >= T1) return "R3";
        return (o > 0 || k >= 24*TB) ? "R5" : "R4";
    endfunction

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            logic [NL-1:0] ev;
            int bad;
            bad = -1;
            for (int o = 0; o < NL; o++) begin
                ev[o] = exp_line(o);
                if (ev[o] != led_out[o] && bad < 0) bad = o;
            end
            chk(bad < 0, (bad < 0) ? "R3" : line_tag(bad), longint'(led_out), longint'(ev));
            chk(busy == (m_act != 0),
                (m_act != 0 && m_t == 0) ? ((m_mid != 0) ? "R9" : "R2") : "R8",
                longint'(busy), longint'(m_act != 0));
            chk(shown_bank == m_bank[0], "R2", longint'(shown_bank), longint'(m_bank));
            if (mem_rd_en)
                chk(int'(mem_rd_addr) >= m_bank*BW && int'(mem_rd_addr) < (m_bank+1)*BW,
                    "R11", longint'(mem_rd_addr), longint'(m_bank*BW));
        end
        if (cyc > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic fill_bank(input int b, input int seed);
        for (int i = 0; i < BW; i++) begin
            int unsigned h;
            h = (i + 1) * 32'h9E3779B1 ^ (seed * 32'h85EBCA6B);
            h = h ^ (h >> 13);
            mem[b*BW + i] = {h[31:24], h[23:0]};
        end
    endtask

    task automatic pulse_commit(input int b);
        @(negedge clk);
        commit = 1'b1; commit_bank = b[0];
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic measure_frame(input int exp_p, output int idle_after);
        int n;
        n = 0;
        while (!busy) @(negedge clk);
        while (busy) begin n++; @(negedge clk); end
        chk(n == LOADC + exp_p*24*TB + RC, "R7", n, LOADC + exp_p*24*TB + RC);
        idle_after = 0;
        while (!busy && idle_after < 4) begin idle_after++; @(negedge clk); end
    endtask

    initial begin
        int idle;
        for (int i = 0; i < 2*BW; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy, "R1", busy, 0);
        chk(led_out == '0, "R1", led_out, 0);
        chk(!shown_bank && !mem_rd_en, "R1", {shown_bank, mem_rd_en}, 0);

        // full width frame, bank 0
        fill_bank(0, 1);
        cfg_lanes = LW'(30); cfg_pixels = PW'(4);
        pulse_commit(0);
        measure_frame(4, idle);

        // bank 1: all-ones next to all-zeros words, 7 lanes, 3 pixels
        fill_bank(1, 2);
        mem[BW + 0] = 32'hFFFF_FFFF;
        mem[BW + 3] = 32'h0000_0000;
        mem[BW + 4] = 32'h0000_FF00;
        cfg_lanes = LW'(7); cfg_pixels = PW'(3);
        pulse_commit(1);
        while (!busy) @(negedge clk);
        repeat (300) @(negedge clk);
        // R6: mid-frame config change must not affect the frame
        cfg_lanes = LW'(30); cfg_pixels = PW'(5);
        fill_bank(0, 3);
        pulse_commit(1);
        repeat (5) @(negedge clk);
        pulse_commit(0);  // R9: newest commit wins
        while (busy) @(negedge clk);
        chk(!busy, "R9", busy, 0);
        @(negedge clk);
        chk(busy && shown_bank == 1'b0, "R9", {busy, shown_bank}, 2'b10);
        measure_frame(5, idle);

        // R6/R7: lane count above maximum, zero length
        fill_bank(1, 4);
        cfg_lanes = LW'(31); cfg_pixels = PW'(0);
        pulse_commit(1);
        measure_frame(1, idle);

        // R6/R7: no lanes, length above maximum
        fill_bank(0, 5);
        cfg_lanes = LW'(0); cfg_pixels = PW'(31);
        pulse_commit(0);
        measure_frame(MP, idle);

        // exact maximum length, partial lanes
        fill_bank(1, 6);
        cfg_lanes = LW'(12); cfg_pixels = PW'(MP);
        pulse_commit(1);
        measure_frame(MP, idle);
        chk(idle == 4 && led_out == '0, "R8", led_out, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule